// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level table tree kept in memory. A request carries the linear address plus two attribute flags: whether the access is a write and whether it comes from user code. Alongside each request the block samples a paging-enable flag and a root base register. With paging off, the address passes through unchanged and memory is not touched. With paging on, the block reads a directory entry and then a table entry over a simple synchronous 32-bit memory port.

Each entry carries a 4 KB-aligned frame number in its upper 20 bits and attribute flags in its low bits. A missing entry or a forbidden access ends the walk with a fault, and the faulting linear address is copied into a held fault-address register. Entries whose accessed flag is clear, and leaf entries reached by a write whose dirty flag is clear, are written back with those flags set before the result appears. One response pulse is produced for every accepted request.

Top module: `page_walker`

## Requirements
- R1: When `paging_on` is 0 at acceptance, `rsp_paddr` equals `req_vaddr`, `rsp_fault` is 0, no memory access is made, and `rsp_valid` is high in the cycle right after the accepting clock edge.
- R2: With paging on, the first access is a read of the directory entry at `{dir_base[31:12], 12'h000} + 4 * vaddr[31:22]`; the low 12 bits of `dir_base` are ignored, and index 1023 reaches the last word of the 4 KB directory.
- R3: The second access is a read of the table entry at `{dir_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R4: A successful walk returns `rsp_paddr = {table_entry[31:12], vaddr[11:0]}` with `rsp_fault` 0.
- R5: An entry with bit 0 (present) clear ends the walk with a fault. A directory fault makes exactly one read and no table read.
- R6: A write request to an entry with bit 1 (writable) clear, or a user request to an entry with bit 2 (user) clear, faults at either level.
- R7: On a fault `fault_addr` takes the request's linear address. It holds its value through later successful or untranslated requests and resets to 0.
- R8: A non-faulting entry with bit 5 (accessed) clear is written back to the same address with bit 5 set and every other bit unchanged, before the response is given.
- R9: A write request that reaches a non-faulting table entry with bit 6 (dirty) clear writes that entry back with bit 6 set. Read requests never set bit 6, and directory entries never get bit 6 set.
- R10: A request is taken only while `req_ready` is high. Each accepted request yields exactly one one-cycle `rsp_valid` pulse, and a held `req_valid` during a walk starts no second walk.
- R11: A faulting entry is never written back. A fault response carries `rsp_paddr` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request comes from user privilege |
| paging_on | input | 1 | Translation enabled (sampled at acceptance) |
| dir_base | input | 32 | Physical base of the directory; low 12 bits ignored |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| fault_addr | output | 32 | Linear address of the latest fault |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry written back |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench aims at the edges of the index fields: the all-ones address that uses directory and table index 1023 and catches a directory base whose low bits leak into the address or an index shifted by the wrong amount. It also covers a fault after the directory accessed flag was already written back. A walker that wrote back too eagerly would mark the faulting table entry, and one that skipped the write-back would leave the directory flag clear. Read and write requests hit the same table entry to separate the accessed and dirty updates, so a design that set dirty on reads or on directory entries shows a wrong memory word. A faulting walk followed by good ones exposes a fault register that is overwritten on success. A request held high during a walk would produce a second response if acceptance were not gated.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_WTHRU    = 3;
  localparam int BIT_NOCACHE  = 4;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_DIRTY    = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR_RD,
    S_DIR_CHK,
    S_DIR_WB,
    S_TBL_RD,
    S_TBL_CHK,
    S_TBL_WB
  } walk_state_e;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int ENT_BYTES = 4
) (
  input  logic [ADDR_W-OFF_W-1:0] frame,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       ent_addr
);
  localparam int SHIFT = $clog2(ENT_BYTES);

  logic [ADDR_W-1:0] base_bytes;
  logic [ADDR_W-1:0] idx_bytes;

  always_comb begin
    base_bytes = {frame, {OFF_W{1'b0}}};
    idx_bytes  = ADDR_W'(idx) << SHIFT;
    ent_addr   = base_bytes + idx_bytes;
  end
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check
  import pw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             leaf,
  input  logic             acc_write,
  input  logic             acc_user,
  output logic             fault,
  output logic             need_wb,
  output logic [ENT_W-1:0] updated
);
  logic set_dirty;

  always_comb begin
    fault = !entry[BIT_PRESENT]
          | (acc_write & !entry[BIT_WRITABLE])
          | (acc_user  & !entry[BIT_USER]);
    set_dirty = leaf & acc_write & !entry[BIT_DIRTY];
    need_wb   = !entry[BIT_ACCESSED] | set_dirty;
    updated   = entry;
    updated[BIT_ACCESSED] = 1'b1;
    if (set_dirty) updated[BIT_DIRTY] = 1'b1;
  end
endmodule

// File: rtl/pw_fault_reg.sv
module pw_fault_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (capture) held <= addr;
  end

  // R7: a capture loads the linear address of the faulting walk
  a_r7_capture_loads: assert property (@(posedge clk) disable iff (rst)
    capture |=> held == $past(addr));

  // R7: without a capture the register keeps its value
  a_r7_holds_value: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(held));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  parameter int ENT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic              paging_on,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata
);
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int TBL_LSB = OFF_W;
  localparam int DIR_LSB = OFF_W + TBL_IDX_W;

  walk_state_e        state;
  logic [ADDR_W-1:0]  vaddr_q;
  logic               wr_q;
  logic               usr_q;
  logic [FRAME_W-1:0] tframe_q;
  logic [ADDR_W-1:0]  pend_q;

  logic [ADDR_W-1:0]  dir_ent_addr;
  logic [ADDR_W-1:0]  tbl_ent_addr;
  logic [FRAME_W-1:0] tbl_frame;
  logic               chk_fault;
  logic               chk_wb;
  logic [ADDR_W-1:0]  chk_upd;
  logic               in_check;
  logic               fault_cap;
  logic               unused_base_lo;

  assign unused_base_lo = ^dir_base[OFF_W-1:0];
  assign req_ready      = (state == S_IDLE);
  assign in_check       = (state == S_DIR_CHK) || (state == S_TBL_CHK);
  assign fault_cap      = in_check && chk_fault;
  assign tbl_frame      = (state == S_DIR_WB) ? tframe_q : mem_rdata[ADDR_W-1:OFF_W];

  pw_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(DIR_IDX_W), .ENT_BYTES(ENT_BYTES)
  ) i_dir_addr (
    .frame    (dir_base[ADDR_W-1:OFF_W]),
    .idx      (req_vaddr[DIR_LSB +: DIR_IDX_W]),
    .ent_addr (dir_ent_addr)
  );

  pw_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(TBL_IDX_W), .ENT_BYTES(ENT_BYTES)
  ) i_tbl_addr (
    .frame    (tbl_frame),
    .idx      (vaddr_q[TBL_LSB +: TBL_IDX_W]),
    .ent_addr (tbl_ent_addr)
  );

  pw_entry_check #(.ENT_W(ADDR_W)) i_check (
    .entry     (mem_rdata),
    .leaf      (state == S_TBL_CHK),
    .acc_write (wr_q),
    .acc_user  (usr_q),
    .fault     (chk_fault),
    .need_wb   (chk_wb),
    .updated   (chk_upd)
  );

  pw_fault_reg #(.ADDR_W(ADDR_W)) i_fault (
    .clk     (clk),
    .rst     (rst),
    .capture (fault_cap),
    .addr    (vaddr_q),
    .held    (fault_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      vaddr_q   <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      tframe_q  <= '0;
      pend_q    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            wr_q    <= req_write;
            usr_q   <= req_user;
            if (!paging_on) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_paddr <= req_vaddr;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= dir_ent_addr;
              state    <= S_DIR_RD;
            end
          end
        end
        S_DIR_RD: begin
          mem_req <= 1'b0;
          state   <= S_DIR_CHK;
        end
        S_DIR_CHK: begin
          if (chk_fault) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            state     <= S_IDLE;
          end else begin
            tframe_q <= mem_rdata[ADDR_W-1:OFF_W];
            mem_req  <= 1'b1;
            if (chk_wb) begin
              mem_we    <= 1'b1;
              mem_wdata <= chk_upd;
              state     <= S_DIR_WB;
            end else begin
              mem_we   <= 1'b0;
              mem_addr <= tbl_ent_addr;
              state    <= S_TBL_RD;
            end
          end
        end
        S_DIR_WB: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= tbl_ent_addr;
          state    <= S_TBL_RD;
        end
        S_TBL_RD: begin
          mem_req <= 1'b0;
          state   <= S_TBL_CHK;
        end
        S_TBL_CHK: begin
          if (chk_fault) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            state     <= S_IDLE;
          end else if (chk_wb) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= chk_upd;
            pend_q    <= {mem_rdata[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
            state     <= S_TBL_WB;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {mem_rdata[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
            state     <= S_IDLE;
          end
        end
        S_TBL_WB: begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_paddr <= pend_q;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: untranslated requests answer next cycle with the same address and no access
  a_r1_bypass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !paging_on) |=>
      (rsp_valid && !rsp_fault && !mem_req && rsp_paddr == $past(req_vaddr)));

  // R2: a translated request starts with a read inside the directory page
  a_r2_dir_first: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && paging_on) |=>
      (mem_req && !mem_we && mem_addr[ADDR_W-1:OFF_W] == $past(dir_base[ADDR_W-1:OFF_W])));

  // R5: a directory fault is followed by no further access
  a_r5_stop_on_dir_fault: assert property (@(posedge clk) disable iff (rst)
    (state == S_DIR_CHK && chk_fault) |=> (!mem_req && rsp_valid && rsp_fault));

  // R8: every written entry has the accessed flag set
  a_r8_wb_accessed: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[BIT_ACCESSED]);

  // R11: only present entries are ever written back
  a_r11_wb_present: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[BIT_PRESENT]);

  // R10: the response is a single-cycle pulse
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R11: a fault response carries a zero address
  a_r11_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> rsp_paddr == '0);

  // R2: entry accesses are word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        req_user;
  logic        paging_on;
  logic [31:0] dir_base;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_paddr;
  logic [31:0] fault_addr;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  always #10 clk = ~clk;

  page_walker i_page_walker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .paging_on(paging_on), .dir_base(dir_base),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fault_addr(fault_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [4096];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[13:2]];
    end
  end

  typedef struct {
    string       tag;
    logic [31:0] paddr;
    logic        fault;
    int          reads;
    int          writes;
    logic [31:0] fa;
    bit          chk_d;
    logic [31:0] da;
    logic [31:0] dv;
    bit          chk_t;
    logic [31:0] ta;
    logic [31:0] tv;
  } exp_t;

  exp_t        sb[$];
  exp_t        mon_e;
  int          checks = 0;
  int          errors = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] exp_fa = 32'h0;
  bit          summary_done = 1'b0;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) wr_cnt++;
      else        rd_cnt++;
    end
  end

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 extra response actual %h expected none", rsp_paddr);
      end else begin
        mon_e = sb.pop_front();
        check32({mon_e.tag, " paddr"}, rsp_paddr, mon_e.paddr);
        check32({mon_e.tag, " fault"}, {31'b0, rsp_fault}, {31'b0, mon_e.fault});
        check32({mon_e.tag, " reads"}, rd_cnt, mon_e.reads);
        check32({mon_e.tag, " writes"}, wr_cnt, mon_e.writes);
        check32({mon_e.tag, " fault_addr R7"}, fault_addr, mon_e.fa);
        if (mon_e.chk_d) check32({mon_e.tag, " dir word"}, mem[mon_e.da[13:2]], mon_e.dv);
        if (mon_e.chk_t) check32({mon_e.tag, " tbl word"}, mem[mon_e.ta[13:2]], mon_e.tv);
      end
    end
  end

  // driver: computes the expected outcome, queues it, then issues the request
  task automatic send(string tag, logic [31:0] va, logic wr, logic usr,
                      logic pg, logic [31:0] base, int hold);
    exp_t        e;
    logic [31:0] de;
    logic [31:0] te;
    e.tag = tag; e.fault = 1'b0; e.reads = 0; e.writes = 0;
    e.chk_d = 1'b0; e.chk_t = 1'b0; e.paddr = va;
    e.da = '0; e.dv = '0; e.ta = '0; e.tv = '0;
    if (pg) begin
      e.da    = {base[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
      de      = mem[e.da[13:2]];
      e.reads = 1;
      e.chk_d = 1'b1;
      e.dv    = de;
      if (!de[0] || (wr && !de[1]) || (usr && !de[2])) begin
        e.fault = 1'b1;
      end else begin
        e.dv = de | 32'h20;
        if (!de[5]) e.writes++;
        e.ta    = {de[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        te      = mem[e.ta[13:2]];
        e.reads = 2;
        e.chk_t = 1'b1;
        e.tv    = te;
        if (!te[0] || (wr && !te[1]) || (usr && !te[2])) begin
          e.fault = 1'b1;
        end else begin
          e.tv = te | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (e.tv != te) e.writes++;
          e.paddr = {te[31:12], va[11:0]};
        end
      end
      if (e.fault) begin
        exp_fa  = va;
        e.paddr = 32'h0;
      end
    end
    e.fa = exp_fa;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    sb.push_back(e);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    paging_on = pg; dir_base = base;
    @(posedge clk);
    @(negedge clk);
    if (!pg) check32({tag, " R1 next-cycle response"}, {31'b0, rsp_valid}, 32'h1);
    for (int h = 0; h < hold; h++) begin
      check32({tag, " R10 ready low while busy"}, {31'b0, req_ready}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    req_user = 1'b0; paging_on = 1'b0; dir_base = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check32("reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check32("reset mem_req", {31'b0, mem_req}, 32'h0);
    check32("reset req_ready", {31'b0, req_ready}, 32'h1);
    check32("reset fault_addr R7", fault_addr, 32'h0);

    // directory at 0x1000, tables at 0x2000 and 0x3000
    mem[12'h403] = 32'h0000_2027;  // dir idx 3: P W U A
    mem[12'h810] = 32'h0500_1067;  // tbl A idx 0x10: P W U A D
    mem[12'h404] = 32'h0000_3007;  // dir idx 4: P W U, A clear
    mem[12'hC05] = 32'h1234_5007;  // tbl B idx 5: P W U, A clear
    mem[12'h406] = 32'h0000_3003;  // dir idx 6: P W, supervisor, A clear
    mem[12'hC08] = 32'h0ABC_D025;  // tbl B idx 8: read-only, A set, D clear
    mem[12'h7FF] = 32'h0000_3027;  // dir idx 1023
    mem[12'hFFF] = 32'hFFFF_F067;  // tbl B idx 1023

    send("R1 bypass", 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 32'h0000_1ABC, 0);
    send("R2 R3 R4 walk", 32'h00C1_08A0, 1'b0, 1'b0, 1'b1, 32'h0000_1ABC, 0);
    send("R8 R9 read sets accessed only", 32'h0100_5123, 1'b0, 1'b1, 1'b1, 32'h0000_1000, 0);
    send("R9 write sets dirty", 32'h0100_5FFF, 1'b1, 1'b1, 1'b1, 32'h0000_1000, 0);
    send("R5 dir not present", 32'h0140_0ABC, 1'b0, 1'b0, 1'b1, 32'h0000_1000, 0);
    send("R5 R11 tbl not present", 32'h0180_7444, 1'b0, 1'b0, 1'b1, 32'h0000_1000, 0);
    send("R6 R11 write to read-only", 32'h0100_8010, 1'b1, 1'b1, 1'b1, 32'h0000_1000, 0);
    send("R6 user to supervisor dir", 32'h0180_7000, 1'b0, 1'b1, 1'b1, 32'h0000_1000, 0);
    send("R7 success keeps fault_addr", 32'h00C1_0004, 1'b0, 1'b0, 1'b1, 32'h0000_1000, 0);
    send("R7 bypass keeps fault_addr", 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 0);
    send("R2 R3 max index", 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0000_1000, 0);
    send("R10 held request", 32'h00C1_08A0, 1'b0, 1'b0, 1'b1, 32'h0000_1000, 2);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule